// File: doc/BRIEF.md
# Configurable Asynchronous Character Transmitter

This block turns a parallel character into an asynchronous serial frame on one output line. A frame is a low start bit, then 5 to 8 data bits least significant bit first, then an optional parity bit, then a high stop period of 1, 1.5 or 2 bit times. Each bit lasts 1, 16, 32 or 64 cycles of the block clock. A 2-bit clock-mode field selects the multiplier.

A host waits for `ready_o`, presents a character and its frame settings, and pulses `load_i`. All settings are captured with the character, so later changes affect only later characters. With auto-enable set, an active-low clear-to-send input decides when a captured character may begin. Once the start bit has begun, the character always runs to its end.

Top module: `act_char_tx`

## Requirements
- R1: While reset is asserted and whenever the block is idle, `txd_o` is high and `ready_o` is high (once out of reset).
- R2: A character is accepted on the clock edge where `load_i` and `ready_o` are both high. `ready_o` is low from the next cycle until the cycle after the last stop clock.
- R3: Without gating, the start bit (low) begins on the cycle after acceptance and lasts one bit period. Data bits follow, least significant bit first, each lasting one bit period.
- R4: The character-length field `char_len_i` selects the number of data bits: 00 = 5, 01 = 7, 10 = 6, 11 = 8. Unused upper bits of `data_i` are not sent.
- R5: With `par_en_i` high, one parity bit follows the last data bit. With it low, the stop period follows the data directly.
- R6: With `par_even_i` high, the parity bit makes the count of ones in data plus parity even. With it low, that count is odd.
- R7: The stop field `stop_sel_i` sets the high stop period: 01 = 1 bit period, 10 = 1.5 bit periods, 11 = 2 bit periods. Code 00 is treated as 1 bit period.
- R8: The clock-mode field `clk_mode_i` sets the bit period in clocks: 00 = 1, 01 = 16, 10 = 32, 11 = 64.
- R9: With stop code 10 in clock mode 00, the stop period is 2 clocks.
- R10: With `auto_en_i` high, an accepted character waits with `txd_o` high and `ready_o` low while `cts_n_i` is high. Its start bit begins the cycle after `cts_n_i` is seen low. With `auto_en_i` low, `cts_n_i` has no effect.
- R11: Once the start bit has begun, a rise of `cts_n_i` does not stop or alter the character.
- R12: Frame settings and data are taken only at acceptance. Changes on those inputs during a character do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, a multiple of the bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Character strobe, taken when ready_o is high |
| data_i | input | 8 | Character to send, bit 0 first |
| ready_o | output | 1 | High when a new character can be accepted |
| par_en_i | input | 1 | Append a parity bit |
| par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| stop_sel_i | input | 2 | Stop period code |
| clk_mode_i | input | 2 | Clocks-per-bit code |
| char_len_i | input | 2 | Data bit count code |
| auto_en_i | input | 1 | Let clear-to-send gate the start of a character |
| cts_n_i | input | 1 | Clear-to-send, active low |
| txd_o | output | 1 | Serial output, idles high |

## Verification
The embedded assertions watch every cycle for these properties:
- the line is high whenever the block is ready and throughout the stop period;
- acceptance drops `ready_o` and, when ungated, starts the low start bit at once;
- a held character stays held while clear-to-send is inactive;
- no state is left before its bit timer expires;
- captured settings never move except at acceptance.

Only the bench scenarios can show that a whole frame is correct. That covers the bit order, the data count for each length code, the parity value for both senses, and the exact stop length for each code and clock mode. It also covers a full character surviving a mid-frame change of clear-to-send or of the setting inputs.

// File: rtl/act_tx_pkg.sv
// Package: shared types and decode helpers for the asynchronous character
// transmitter. Assumes a maximum clock multiplier of 64.
package act_tx_pkg;

    localparam int MAX_MULT = 64;
    localparam int CNT_W    = $clog2(2 * MAX_MULT);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic       par_en;
        logic       par_even;
        logic [1:0] stop_sel;
        logic [1:0] clk_mode;
        logic [1:0] char_len;
        logic       auto_en;
    } tx_cfg_t;

    // Number of data bits for a length code.
    function automatic int unsigned char_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 5;
            2'b01:   return 7;
            2'b10:   return 6;
            default: return 8;
        endcase
    endfunction

    // Clocks per bit for a clock-mode code.
    function automatic int unsigned clk_mult(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 16;
            2'b10:   return 32;
            default: return 64;
        endcase
    endfunction

endpackage

// File: rtl/tx_bit_timer.sv
// Module: tx_bit_timer
// Down-counter that measures one bit or stop period. A load writes the period
// length minus one; last_o is high in the final clock of the period.
// Assumes the controller reloads it on every state entry.
module tx_bit_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_m1_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load the period or count down to zero and rest there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_m1_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == '0);

endmodule

// File: rtl/tx_parity_gen.sv
// Module: tx_parity_gen
// Parity of the captured character over the selected number of data bits.
// Assumes the data and settings are stable for the whole character.
module tx_parity_gen #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [1:0]        char_len_i,
    input  logic              even_i,
    output logic              par_o
);
    import act_tx_pkg::*;

    localparam int LEN_W = $clog2(DATA_W + 1);

    logic [LEN_W-1:0]  nbits;
    logic [DATA_W-1:0] keep;

    assign nbits = LEN_W'(char_bits(char_len_i));

    // One mask bit per data position: set when the position is inside the character.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign keep[i] = (LEN_W'(i) < nbits);
    end

    // Even sense: the bit equals the XOR of the data; odd sense: its inverse.
    always_comb begin
        par_o = ^(data_i & keep);
        if (!even_i) begin
            par_o = ~par_o;
        end
    end

endmodule

// File: rtl/tx_frame_fsm.sv
// Module: tx_frame_fsm
// Frame sequencer: accepts a character, optionally waits for clear-to-send,
// then steps through start, data, parity and stop, drawing each period from
// the bit timer. Assumes cts_n_i is already synchronous to clk.
module tx_frame_fsm #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [DATA_W-1:0]    data_i,
    input  act_tx_pkg::tx_cfg_t  cfg_i,
    input  logic                 cts_n_i,
    input  logic                 tmr_last_i,
    input  logic                 par_bit_i,
    output logic                 tmr_load_o,
    output logic [CNT_W-1:0]     tmr_len_m1_o,
    output act_tx_pkg::tx_cfg_t  cfg_q_o,
    output logic [DATA_W-1:0]    data_q_o,
    output logic                 ready_o,
    output logic                 txd_o
);
    import act_tx_pkg::*;

    localparam int BIT_W = $clog2(DATA_W + 1);

    tx_state_e        state_q, state_d;
    tx_cfg_t          cfg_q;
    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] data_q;
    logic [BIT_W-1:0] bit_q;
    logic             accept;
    logic             go_now;
    logic             go_held;
    logic [CNT_W-1:0] bit_m1_new;
    logic [CNT_W-1:0] bit_m1;
    logic [CNT_W-1:0] stop_m1;
    logic [BIT_W-1:0] last_bit;

    assign accept   = load_i && (state_q == ST_IDLE);
    assign go_now   = !cfg_i.auto_en || !cts_n_i;
    assign go_held  = !cfg_q.auto_en || !cts_n_i;
    assign last_bit = BIT_W'(char_bits(cfg_q.char_len) - 1);

    // Bit period lengths for the incoming and the captured settings.
    always_comb begin
        bit_m1_new = CNT_W'(clk_mult(cfg_i.clk_mode) - 1);
        bit_m1     = CNT_W'(clk_mult(cfg_q.clk_mode) - 1);
    end

    // Stop period length from the captured stop code and clock mode.
    always_comb begin
        case (cfg_q.stop_sel)
            2'b10: begin
                if (cfg_q.clk_mode == 2'b00) begin
                    stop_m1 = CNT_W'(1);
                end else begin
                    stop_m1 = CNT_W'((3 * clk_mult(cfg_q.clk_mode)) / 2 - 1);
                end
            end
            2'b11:   stop_m1 = CNT_W'(2 * clk_mult(cfg_q.clk_mode) - 1);
            default: stop_m1 = bit_m1;
        endcase
    end

    // Next state and timer reload decisions.
    always_comb begin
        state_d      = state_q;
        tmr_load_o   = 1'b0;
        tmr_len_m1_o = bit_m1;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d      = go_now ? ST_START : ST_HOLD;
                    tmr_load_o   = 1'b1;
                    tmr_len_m1_o = bit_m1_new;
                end
            end
            ST_HOLD: begin
                if (go_held) begin
                    state_d    = ST_START;
                    tmr_load_o = 1'b1;
                end
            end
            ST_START: begin
                if (tmr_last_i) begin
                    state_d    = ST_DATA;
                    tmr_load_o = 1'b1;
                end
            end
            ST_DATA: begin
                if (tmr_last_i) begin
                    tmr_load_o = 1'b1;
                    if (bit_q != last_bit) begin
                        state_d = ST_DATA;
                    end else if (cfg_q.par_en) begin
                        state_d = ST_PARITY;
                    end else begin
                        state_d      = ST_STOP;
                        tmr_len_m1_o = stop_m1;
                    end
                end
            end
            ST_PARITY: begin
                if (tmr_last_i) begin
                    state_d      = ST_STOP;
                    tmr_load_o   = 1'b1;
                    tmr_len_m1_o = stop_m1;
                end
            end
            ST_STOP: begin
                if (tmr_last_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture the character and settings at acceptance; shift during data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            data_q  <= '0;
            shift_q <= '0;
            bit_q   <= '0;
        end else if (accept) begin
            cfg_q   <= cfg_i;
            data_q  <= data_i;
            shift_q <= data_i;
            bit_q   <= '0;
        end else if (state_q == ST_DATA && tmr_last_i) begin
            shift_q <= shift_q >> 1;
            bit_q   <= bit_q + 1'b1;
        end
    end

    // Line level for each state.
    always_comb begin
        case (state_q)
            ST_START:  txd_o = 1'b0;
            ST_DATA:   txd_o = shift_q[0];
            ST_PARITY: txd_o = par_bit_i;
            default:   txd_o = 1'b1;
        endcase
    end

    assign ready_o  = (state_q == ST_IDLE);
    assign cfg_q_o  = cfg_q;
    assign data_q_o = data_q;

    // R10: a gated character stays held while clear-to-send is inactive.
    p_hold_while_cts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && cfg_q.auto_en && cts_n_i) |=> (state_q == ST_HOLD));

    // R8: an active bit state is left only when its timer expires.
    p_no_early_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_START, ST_PARITY, ST_STOP} && !tmr_last_i)
        |=> (state_q == $past(state_q)));

    // R12: captured settings change only on an accepted load.
    p_cfg_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(cfg_q) && $stable(data_q)));

    // R7: the line is high throughout the stop period.
    p_stop_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |-> txd_o);

endmodule

// File: rtl/act_char_tx.sv
// Module: act_char_tx
// Top of the configurable asynchronous character transmitter: joins the frame
// sequencer, the bit timer and the parity generator. Assumes all inputs are
// synchronous to clk.
module act_char_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ready_o,
    input  logic              par_en_i,
    input  logic              par_even_i,
    input  logic [1:0]        stop_sel_i,
    input  logic [1:0]        clk_mode_i,
    input  logic [1:0]        char_len_i,
    input  logic              auto_en_i,
    input  logic              cts_n_i,
    output logic              txd_o
);
    import act_tx_pkg::*;

    tx_cfg_t           cfg_in;
    tx_cfg_t           cfg_q;
    logic [DATA_W-1:0] data_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_len_m1;
    logic              tmr_last;
    logic              par_bit;

    // Gather the setting inputs into one word.
    always_comb begin
        cfg_in.par_en   = par_en_i;
        cfg_in.par_even = par_even_i;
        cfg_in.stop_sel = stop_sel_i;
        cfg_in.clk_mode = clk_mode_i;
        cfg_in.char_len = char_len_i;
        cfg_in.auto_en  = auto_en_i;
    end

    tx_frame_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_i),
        .data_i       (data_i),
        .cfg_i        (cfg_in),
        .cts_n_i      (cts_n_i),
        .tmr_last_i   (tmr_last),
        .par_bit_i    (par_bit),
        .tmr_load_o   (tmr_load),
        .tmr_len_m1_o (tmr_len_m1),
        .cfg_q_o      (cfg_q),
        .data_q_o     (data_q),
        .ready_o      (ready_o),
        .txd_o        (txd_o)
    );

    tx_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .len_m1_i (tmr_len_m1),
        .last_o   (tmr_last)
    );

    tx_parity_gen #(.DATA_W(DATA_W)) u_parity (
        .data_i     (data_q),
        .char_len_i (cfg_q.char_len),
        .even_i     (cfg_q.par_even),
        .par_o      (par_bit)
    );

    // R1: whenever the block is ready the line idles high.
    p_ready_line_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> txd_o);

    // R2: an accepted load drops ready on the next cycle.
    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ready_o) |=> !ready_o);

    // R3: an ungated accepted load starts the low start bit at once.
    p_start_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ready_o && (!auto_en_i || !cts_n_i)) |=> !txd_o);

endmodule

// File: tb/act_char_tx_tb.sv
`timescale 1ns/1ps
module act_char_tx_tb_top;

    typedef struct {
        logic [11:0] bits;
        int          nbits;
        int          per;
        int          stop_clks;
        string       tag;
    } frame_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [7:0] data_i = '0;
    logic       ready_o;
    logic       par_en_i = 1'b0;
    logic       par_even_i = 1'b0;
    logic [1:0] stop_sel_i = 2'b01;
    logic [1:0] clk_mode_i = 2'b01;
    logic [1:0] char_len_i = 2'b11;
    logic       auto_en_i = 1'b0;
    logic       cts_n_i = 1'b1;
    logic       txd_o;

    int checks = 0;
    int fails = 0;
    bit mon_busy = 1'b0;
    frame_t exp_q[$];

    always #2 clk = ~clk;

    act_char_tx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_i),
        .data_i     (data_i),
        .ready_o    (ready_o),
        .par_en_i   (par_en_i),
        .par_even_i (par_even_i),
        .stop_sel_i (stop_sel_i),
        .clk_mode_i (clk_mode_i),
        .char_len_i (char_len_i),
        .auto_en_i  (auto_en_i),
        .cts_n_i    (cts_n_i),
        .txd_o      (txd_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: wait for ready, load a character, queue its expected frame, then scramble settings (R12).
    task automatic send(input logic [7:0] d, input logic pe, input logic pev,
                        input logic [1:0] ss, input logic [1:0] cm, input logic [1:0] cl,
                        input logic ae, input string tag);
        frame_t f;
        int n, per, ones;
        while (!ready_o) @(negedge clk);
        data_i = d; par_en_i = pe; par_even_i = pev; stop_sel_i = ss;
        clk_mode_i = cm; char_len_i = cl; auto_en_i = ae; load_i = 1'b1;
        n   = (cl == 2'b00) ? 5 : (cl == 2'b01) ? 7 : (cl == 2'b10) ? 6 : 8;
        per = (cm == 2'b00) ? 1 : (cm == 2'b01) ? 16 : (cm == 2'b10) ? 32 : 64;
        f.bits = '0;
        f.bits[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            f.bits[i+1] = d[i];
            ones += int'(d[i]);
        end
        f.nbits = n + 1;
        if (pe) begin
            f.bits[n+1] = pev ? logic'(ones % 2) : logic'(1 - ones % 2);
            f.nbits = n + 2;
        end
        f.per = per;
        if (ss == 2'b10) f.stop_clks = (cm == 2'b00) ? 2 : (3 * per) / 2;
        else if (ss == 2'b11) f.stop_clks = 2 * per;
        else f.stop_clks = per;
        f.tag = tag;
        exp_q.push_back(f);
        @(negedge clk);
        load_i = 1'b0;
        data_i = ~d; par_en_i = ~pe; par_even_i = ~pev; stop_sel_i = ~ss;
        clk_mode_i = ~cm; char_len_i = ~cl;
    endtask

    // Monitor: on a start bit, pop the expected frame and compare every clock of it.
    initial begin
        frame_t f;
        bit bad;
        forever begin
            @(negedge clk);
            if (rst_n && !mon_busy && txd_o === 1'b0) begin
                mon_busy = 1'b1;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected start bit", 0, 1);
                end else begin
                    f = exp_q.pop_front();
                    for (int b = 0; b < f.nbits; b++) begin
                        bad = 1'b0;
                        for (int k = 0; k < f.per; k++) begin
                            if (!(b == 0 && k == 0)) @(negedge clk);
                            if (txd_o !== f.bits[b]) bad = 1'b1;
                        end
                        check(!bad, {f.tag, " frame bit"}, b, int'(f.bits[b]));
                    end
                    bad = 1'b0;
                    for (int k = 0; k < f.stop_clks; k++) begin
                        @(negedge clk);
                        if (txd_o !== 1'b1 || ready_o !== 1'b0) bad = 1'b1;
                    end
                    check(!bad, {f.tag, " R7 stop period"}, 0, f.stop_clks);
                    @(negedge clk);
                    check(ready_o === 1'b1 && txd_o === 1'b1, {f.tag, " R2 ready after stop"},
                          int'(ready_o), 1);
                end
                mon_busy = 1'b0;
            end
        end
    end

    task automatic drain();
        @(negedge clk);
        while (exp_q.size() != 0 || mon_busy || !ready_o) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit bad;
        repeat (3) @(negedge clk);
        check(txd_o === 1'b1, "R1 line high in reset", int'(txd_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready_o === 1'b1, "R1 ready after reset", int'(ready_o), 1);
        check(txd_o === 1'b1, "R1 line idle high", int'(txd_o), 1);

        // R3 R8: 8 bits, no parity, x16
        send(8'hA5, 1'b0, 1'b0, 2'b01, 2'b01, 2'b11, 1'b0, "R3 R8 x16 8N1");
        // R4: lengths 5, 6, 7 in x1 with upper bits set
        send(8'hF3, 1'b0, 1'b0, 2'b01, 2'b00, 2'b00, 1'b0, "R4 len5");
        send(8'hDA, 1'b0, 1'b0, 2'b01, 2'b00, 2'b10, 1'b0, "R4 len6");
        send(8'h96, 1'b0, 1'b0, 2'b01, 2'b00, 2'b01, 1'b0, "R4 len7");
        // R5 R6: parity senses
        send(8'h07, 1'b1, 1'b1, 2'b01, 2'b01, 2'b11, 1'b0, "R5 R6 even");
        send(8'h07, 1'b1, 1'b0, 2'b01, 2'b01, 2'b11, 1'b0, "R5 R6 odd");
        send(8'hFF, 1'b1, 1'b1, 2'b01, 2'b00, 2'b00, 1'b0, "R6 even len5");
        // R7: stop codes in x16
        send(8'h3C, 1'b0, 1'b0, 2'b10, 2'b01, 2'b11, 1'b0, "R7 stop1.5");
        send(8'h3C, 1'b1, 1'b0, 2'b11, 2'b01, 2'b11, 1'b0, "R7 stop2");
        send(8'h3C, 1'b0, 1'b0, 2'b00, 2'b01, 2'b11, 1'b0, "R7 stop code00");
        // R9: 1.5 stop in x1
        send(8'h55, 1'b0, 1'b0, 2'b10, 2'b00, 2'b11, 1'b0, "R9 x1 stop1.5");
        // R8: x32 and x64
        send(8'h81, 1'b1, 1'b1, 2'b01, 2'b10, 2'b11, 1'b0, "R8 x32");
        send(8'h6E, 1'b0, 1'b0, 2'b11, 2'b11, 2'b10, 1'b0, "R8 x64");
        drain();

        // R10: auto-enable with clear-to-send inactive holds the character
        cts_n_i = 1'b1;
        send(8'hC3, 1'b1, 1'b0, 2'b01, 2'b01, 2'b11, 1'b1, "R10 held then sent");
        bad = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (txd_o !== 1'b1 || ready_o !== 1'b0) bad = 1'b1;
        end
        check(!bad, "R10 hold while cts inactive", int'(txd_o), 1);
        cts_n_i = 1'b0;
        drain();

        // R10: auto-enable low ignores clear-to-send
        cts_n_i = 1'b1;
        send(8'h5A, 1'b0, 1'b0, 2'b01, 2'b01, 2'b11, 1'b0, "R10 cts ignored");
        drain();

        // R11: clear-to-send rising mid-character does not stop it
        cts_n_i = 1'b0;
        send(8'h99, 1'b1, 1'b1, 2'b11, 2'b01, 2'b11, 1'b1, "R11 completes");
        repeat (40) @(negedge clk);
        cts_n_i = 1'b1;
        drain();
        cts_n_i = 1'b0;

        check(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule